// File: doc/BRIEF.md
# In-Order Retire and Flush Unit

This block tracks every in-flight instruction of an out-of-order core from dispatch to retirement. The dispatch stage allocates a group of consecutive entries in program order and receives the tag of the first one. Execution units later report a finish against a tag, in any order. A finish carries an exception flag and a mispredict flag with a redirect target. A unit that hits an exception still reports a finish and carries on; the fault is acted on only when the entry becomes the oldest one.

Each cycle the unit retires a run of the oldest finished entries, oldest first. For each retired entry it raises a rename-commit strobe. An entry marked at dispatch for early commit is committed to the architectural file in the completion cycle. Every other retired entry enters a one-cycle writeback stage and is committed from there. Special-register updates (condition, count, link) are signalled in the completion cycle.

When the completing entry carries an exception, it is dropped without retiring. When it carries a mispredict, it retires as the last lane of that cycle. In both cases every younger entry is cancelled, the buffer empties, allocation resumes just past the offending entry, and a redirect with the correct fetch address is raised.

Top module: `inorder_retire_unit`

## Requirements
- R1: After reset the buffer is empty: no retire, commit, writeback or flush strobe is high, `dispTag` is 0 and a request of up to `DISP_W` entries is granted.
- R2: A granted request of N entries allocates tags `dispTag` to `dispTag`+N-1 (modulo `DEPTH`), lane i taking `dispTag`+i, and the next grant continues from `dispTag`+N.
- R3: A request is granted exactly when its count does not exceed the free entries and no flush is raised in that cycle; a refused request allocates nothing.
- R4: Up to `RET_W` entries retire per cycle, oldest first: `retValid` is a prefix mask and lane k carries tag `retTag[0]`+k.
- R5: Retirement stops at the oldest unfinished entry; younger finished entries wait until it finishes.
- R6: A finished entry with the exception flag at the retire point is not retired; in that cycle `flushValid` is high, `flushTag` is its tag and `flushPc` equals `EXC_VEC`, while older finished entries in the window still retire.
- R7: A finished entry with the mispredict flag retires as the last valid lane, with `flushValid` high, `flushTag` its tag and `flushPc` the target reported with its finish.
- R8: In the cycle after a flush nothing retires, no flush is raised, and `dispTag` equals the flushed tag plus one; all entries that were younger are cancelled.
- R9: `commitValid[k]` is high in the retire cycle exactly when lane k retires an entry dispatched with its early-commit bit set.
- R10: One cycle after lane k retires an entry without early commit, `wbValid[k]` is high and `wbTag` lane k holds that tag; otherwise `wbValid[k]` is low.
- R11: `retSpr[k]` is high in the retire cycle exactly when lane k retires an entry dispatched with its special-register bit set.
- R12: Finish reports are taken every cycle, for any live tag and in any order, with no back-pressure, whether or not they carry an exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dispCount | input | $clog2(DISP_W+1) | Number of entries requested this cycle |
| dispEarly | input | DISP_W | Per lane: commit in the completion cycle |
| dispSpr | input | DISP_W | Per lane: entry updates a special register |
| dispGrant | output | 1 | Request accepted |
| dispTag | output | $clog2(DEPTH) | Tag of lane 0 of the group |
| finValid | input | FIN_W | Finish report valid per port |
| finTag | input | FIN_W*$clog2(DEPTH) | Tag per finish port |
| finExc | input | FIN_W | Exception flag per finish port |
| finMisp | input | FIN_W | Mispredict flag per finish port |
| finTarget | input | FIN_W*TGT_W | Redirect target per finish port |
| retValid | output | RET_W | Retire strobe per lane |
| retTag | output | RET_W*$clog2(DEPTH) | Tag per retire lane |
| commitValid | output | RET_W | Early rename commit per lane |
| retSpr | output | RET_W | Special-register update per lane |
| wbValid | output | RET_W | Deferred writeback commit per lane |
| wbTag | output | RET_W*$clog2(DEPTH) | Tag per writeback lane |
| flushValid | output | 1 | Cancel younger entries and redirect |
| flushTag | output | $clog2(DEPTH) | Tag of the faulting or mispredicted entry |
| flushPc | output | TGT_W | Refetch address |

## Verification
The checks take for granted that finish reports name only live, not yet finished tags, that no finish names an entry cancelled by a flush, and that the dispatch count is zero while reset is held. The stimulus keeps to this by issuing each finish once, against tags it tracks itself. It finishes the younger entries of a flush scenario before the faulting entry reaches the retire point, so no report arrives for a cancelled entry. The occupancy the assertions compare against is rebuilt at the ports from grants, retire strobes and flushes.

// File: rtl/retire_pkg.sv
package retire_pkg;

  // Strobes from the control side to the entry storage.
  typedef struct packed {
    logic allocEn;  // write the requested group at the tail
    logic flushEn;  // cancel every live entry
  } retStrobe_t;

endpackage

// File: rtl/retire_data.sv
module retire_data
  import retire_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DISP_W = 4,
  parameter int FIN_W  = 2,
  parameter int RET_W  = 4,
  parameter int TGT_W  = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int DC_W  = $clog2(DISP_W + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  retStrobe_t             strobe,
  input  logic [IDX_W-1:0]       tailPtr,
  input  logic [IDX_W-1:0]       headPtr,
  input  logic [DC_W-1:0]        dispCount,
  input  logic [DISP_W-1:0]      dispEarly,
  input  logic [DISP_W-1:0]      dispSpr,
  input  logic [FIN_W-1:0]       finValid,
  input  logic [FIN_W*IDX_W-1:0] finTag,
  input  logic [FIN_W-1:0]       finExc,
  input  logic [FIN_W-1:0]       finMisp,
  input  logic [FIN_W*TGT_W-1:0] finTarget,
  output logic [RET_W-1:0]       winDone,
  output logic [RET_W-1:0]       winExc,
  output logic [RET_W-1:0]       winMisp,
  output logic [RET_W-1:0]       winEarly,
  output logic [RET_W-1:0]       winSpr,
  output logic [RET_W*TGT_W-1:0] winTarget
);

  logic [DEPTH-1:0] doneQ, excQ, mispQ, earlyQ, sprQ;
  logic [TGT_W-1:0] tgtQ [DEPTH];

  logic [IDX_W-1:0] allocOff [DEPTH];
  logic [DEPTH-1:0] allocHit, newEarly, newSpr;
  logic [DEPTH-1:0] finHit, finExcN, finMispN;
  logic [TGT_W-1:0] finTgtN [DEPTH];

  // Which entries the current dispatch group writes, and with what.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      allocOff[i] = IDX_W'(i) - tailPtr;
      allocHit[i] = strobe.allocEn && (int'(allocOff[i]) < int'(dispCount));
      newEarly[i] = dispEarly[int'(allocOff[i]) % DISP_W];
      newSpr[i]   = dispSpr[int'(allocOff[i]) % DISP_W];
    end
  end

  // Finish reports decoded per entry; a higher port wins on a tag clash.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      finHit[i]   = 1'b0;
      finExcN[i]  = 1'b0;
      finMispN[i] = 1'b0;
      finTgtN[i]  = '0;
      for (int f = 0; f < FIN_W; f++) begin
        if (finValid[f] && finTag[f*IDX_W +: IDX_W] == IDX_W'(i)) begin
          finHit[i]   = 1'b1;
          finExcN[i]  = finExc[f];
          finMispN[i] = finMisp[f];
          finTgtN[i]  = finTarget[f*TGT_W +: TGT_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      doneQ  <= '0;
      excQ   <= '0;
      mispQ  <= '0;
      earlyQ <= '0;
      sprQ   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strobe.flushEn) begin
          doneQ[i] <= 1'b0;
        end else if (allocHit[i]) begin
          doneQ[i]  <= 1'b0;
          excQ[i]   <= 1'b0;
          mispQ[i]  <= 1'b0;
          earlyQ[i] <= newEarly[i];
          sprQ[i]   <= newSpr[i];
        end else if (finHit[i]) begin
          doneQ[i] <= 1'b1;
          excQ[i]  <= finExcN[i];
          mispQ[i] <= finMispN[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (finHit[i]) tgtQ[i] <= finTgtN[i];
    end
  end

  // Retire window: the RET_W oldest slots starting at the head.
  always_comb begin
    for (int k = 0; k < RET_W; k++) begin
      logic [IDX_W-1:0] widx;
      widx = headPtr + IDX_W'(k);
      winDone[k]  = doneQ[widx];
      winExc[k]   = excQ[widx];
      winMisp[k]  = mispQ[widx];
      winEarly[k] = earlyQ[widx];
      winSpr[k]   = sprQ[widx];
      winTarget[k*TGT_W +: TGT_W] = tgtQ[widx];
    end
  end

endmodule

// File: rtl/retire_ctrl.sv
module retire_ctrl
  import retire_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DISP_W = 4,
  parameter int RET_W  = 4,
  parameter int TGT_W  = 32,
  parameter logic [TGT_W-1:0] EXC_VEC = 'h100,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int DC_W  = $clog2(DISP_W + 1),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DC_W-1:0]        dispCount,
  input  logic [RET_W-1:0]       winDone,
  input  logic [RET_W-1:0]       winExc,
  input  logic [RET_W-1:0]       winMisp,
  input  logic [RET_W-1:0]       winEarly,
  input  logic [RET_W-1:0]       winSpr,
  input  logic [RET_W*TGT_W-1:0] winTarget,
  output retStrobe_t             strobe,
  output logic [IDX_W-1:0]       tailPtr,
  output logic [IDX_W-1:0]       headPtr,
  output logic                   dispGrant,
  output logic [IDX_W-1:0]       dispTag,
  output logic [RET_W-1:0]       retValid,
  output logic [RET_W*IDX_W-1:0] retTag,
  output logic [RET_W-1:0]       commitValid,
  output logic [RET_W-1:0]       retSpr,
  output logic [RET_W-1:0]       wbValid,
  output logic [RET_W*IDX_W-1:0] wbTag,
  output logic                   flushValid,
  output logic [IDX_W-1:0]       flushTag,
  output logic [TGT_W-1:0]       flushPc
);

  logic [IDX_W-1:0] headQ, tailQ;
  logic [CNT_W-1:0] cntQ, freeN;
  logic [RET_W-1:0] wbValidQ;
  logic [RET_W*IDX_W-1:0] wbTagQ;
  int retN;

  // Scan the window oldest first; stop at the first unfinished or faulting entry.
  always_comb begin
    logic stop;
    stop       = 1'b0;
    retN       = 0;
    retValid   = '0;
    flushValid = 1'b0;
    flushTag   = '0;
    flushPc    = '0;
    for (int k = 0; k < RET_W; k++) begin
      retTag[k*IDX_W +: IDX_W] = headQ + IDX_W'(k);
      if (!stop) begin
        if (k < int'(cntQ) && winDone[k]) begin
          if (winExc[k]) begin
            flushValid = 1'b1;
            flushTag   = headQ + IDX_W'(k);
            flushPc    = EXC_VEC;
            stop       = 1'b1;
          end else begin
            retValid[k] = 1'b1;
            retN        = k + 1;
            if (winMisp[k]) begin
              flushValid = 1'b1;
              flushTag   = headQ + IDX_W'(k);
              flushPc    = winTarget[k*TGT_W +: TGT_W];
              stop       = 1'b1;
            end
          end
        end else begin
          stop = 1'b1;
        end
      end
    end
  end

  assign freeN          = CNT_W'(DEPTH) - cntQ;
  assign dispGrant      = !flushValid && (int'(dispCount) <= int'(freeN));
  assign dispTag        = tailQ;
  assign strobe.allocEn = dispGrant && (dispCount != '0);
  assign strobe.flushEn = flushValid;
  assign commitValid    = retValid & winEarly;
  assign retSpr         = retValid & winSpr;
  assign headPtr        = headQ;
  assign tailPtr        = tailQ;
  assign wbValid        = wbValidQ;
  assign wbTag          = wbTagQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      headQ    <= '0;
      tailQ    <= '0;
      cntQ     <= '0;
      wbValidQ <= '0;
      wbTagQ   <= '0;
    end else begin
      wbValidQ <= retValid & ~winEarly;
      wbTagQ   <= retTag;
      if (flushValid) begin
        headQ <= flushTag + 1'b1;
        tailQ <= flushTag + 1'b1;
        cntQ  <= '0;
      end else begin
        headQ <= headQ + IDX_W'(retN);
        if (strobe.allocEn) begin
          tailQ <= tailQ + IDX_W'(dispCount);
          cntQ  <= cntQ - CNT_W'(retN) + CNT_W'(dispCount);
        end else begin
          cntQ  <= cntQ - CNT_W'(retN);
        end
      end
    end
  end

endmodule

// File: rtl/inorder_retire_unit.sv
module inorder_retire_unit
  import retire_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DISP_W = 4,
  parameter int FIN_W  = 2,
  parameter int RET_W  = 4,
  parameter int TGT_W  = 32,
  parameter logic [TGT_W-1:0] EXC_VEC = 'h100,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int DC_W  = $clog2(DISP_W + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DC_W-1:0]        dispCount,
  input  logic [DISP_W-1:0]      dispEarly,
  input  logic [DISP_W-1:0]      dispSpr,
  output logic                   dispGrant,
  output logic [IDX_W-1:0]       dispTag,
  input  logic [FIN_W-1:0]       finValid,
  input  logic [FIN_W*IDX_W-1:0] finTag,
  input  logic [FIN_W-1:0]       finExc,
  input  logic [FIN_W-1:0]       finMisp,
  input  logic [FIN_W*TGT_W-1:0] finTarget,
  output logic [RET_W-1:0]       retValid,
  output logic [RET_W*IDX_W-1:0] retTag,
  output logic [RET_W-1:0]       commitValid,
  output logic [RET_W-1:0]       retSpr,
  output logic [RET_W-1:0]       wbValid,
  output logic [RET_W*IDX_W-1:0] wbTag,
  output logic                   flushValid,
  output logic [IDX_W-1:0]       flushTag,
  output logic [TGT_W-1:0]       flushPc
);

  retStrobe_t strobe;
  logic [IDX_W-1:0] tailPtr, headPtr;
  logic [RET_W-1:0] winDone, winExc, winMisp, winEarly, winSpr;
  logic [RET_W*TGT_W-1:0] winTarget;

  retire_ctrl #(
    .DEPTH(DEPTH), .DISP_W(DISP_W), .RET_W(RET_W), .TGT_W(TGT_W), .EXC_VEC(EXC_VEC)
  ) ctrl (
    .clk(clk), .rst_n(rst_n), .dispCount(dispCount),
    .winDone(winDone), .winExc(winExc), .winMisp(winMisp),
    .winEarly(winEarly), .winSpr(winSpr), .winTarget(winTarget),
    .strobe(strobe), .tailPtr(tailPtr), .headPtr(headPtr),
    .dispGrant(dispGrant), .dispTag(dispTag),
    .retValid(retValid), .retTag(retTag), .commitValid(commitValid), .retSpr(retSpr),
    .wbValid(wbValid), .wbTag(wbTag),
    .flushValid(flushValid), .flushTag(flushTag), .flushPc(flushPc)
  );

  retire_data #(
    .DEPTH(DEPTH), .DISP_W(DISP_W), .FIN_W(FIN_W), .RET_W(RET_W), .TGT_W(TGT_W)
  ) data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .tailPtr(tailPtr), .headPtr(headPtr),
    .dispCount(dispCount), .dispEarly(dispEarly), .dispSpr(dispSpr),
    .finValid(finValid), .finTag(finTag), .finExc(finExc), .finMisp(finMisp),
    .finTarget(finTarget),
    .winDone(winDone), .winExc(winExc), .winMisp(winMisp),
    .winEarly(winEarly), .winSpr(winSpr), .winTarget(winTarget)
  );

endmodule

// File: rtl/retire_checker.sv
module retire_checker #(
  parameter int DEPTH  = 16,
  parameter int DISP_W = 4,
  parameter int RET_W  = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int DC_W  = $clog2(DISP_W + 1),
  localparam int OCC_W = $clog2(DEPTH + 1) + 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [DC_W-1:0]        dispCount,
  input logic                   dispGrant,
  input logic [IDX_W-1:0]       dispTag,
  input logic [RET_W-1:0]       retValid,
  input logic [RET_W*IDX_W-1:0] retTag,
  input logic [RET_W-1:0]       commitValid,
  input logic [RET_W-1:0]       wbValid,
  input logic                   flushValid,
  input logic [IDX_W-1:0]       flushTag
);

  logic [OCC_W-1:0] occ;
  logic armed;

  // Occupancy rebuilt from port activity only.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ   <= '0;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (flushValid) occ <= '0;
      else occ <= occ - OCC_W'($countones(retValid))
                      + (dispGrant ? OCC_W'(dispCount) : '0);
    end
  end

  // R3
  grant_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dispGrant |-> (int'(occ) + int'(dispCount) <= DEPTH));

  // R3
  refuse_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flushValid && (int'(occ) + int'(dispCount) <= DEPTH)) |-> dispGrant);

  // R2
  alloc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(dispGrant) && !$past(flushValid))
      |-> dispTag == IDX_W'($past(dispTag) + IDX_W'($past(dispCount))));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flushValid |=> (!retValid[0] && !flushValid && dispTag == IDX_W'($past(flushTag) + 1'b1)));

  // R9
  commit_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commitValid & ~retValid) == '0);

  // R10
  wb_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> wbValid == $past(retValid & ~commitValid));

  // R4
  generate
    for (genvar k = 1; k < RET_W; k++) begin : g_lane
      retire_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retValid[k] |-> (retValid[k-1] &&
          retTag[k*IDX_W +: IDX_W] == IDX_W'(retTag[(k-1)*IDX_W +: IDX_W] + 1'b1)));
    end
  endgenerate

endmodule

bind inorder_retire_unit retire_checker #(
  .DEPTH(DEPTH), .DISP_W(DISP_W), .RET_W(RET_W)
) u_retire_checker (
  .clk(clk), .rst_n(rst_n), .dispCount(dispCount), .dispGrant(dispGrant),
  .dispTag(dispTag), .retValid(retValid), .retTag(retTag),
  .commitValid(commitValid), .wbValid(wbValid),
  .flushValid(flushValid), .flushTag(flushTag)
);

// File: tb/inorder_retire_unit_test.sv
module inorder_retire_unit_test;

  localparam int DEPTH = 16, DISP_W = 4, FIN_W = 2, RET_W = 4, TGT_W = 32;
  localparam int IDX_W = 4, DC_W = 3;
  localparam logic [31:0] EXC_VEC = 32'h100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DC_W-1:0] dispCount = '0;
  logic [DISP_W-1:0] dispEarly = '0, dispSpr = '0;
  logic dispGrant;
  logic [IDX_W-1:0] dispTag;
  logic [FIN_W-1:0] finValid = '0, finExc = '0, finMisp = '0;
  logic [FIN_W*IDX_W-1:0] finTag = '0;
  logic [FIN_W*TGT_W-1:0] finTarget = '0;
  logic [RET_W-1:0] retValid, commitValid, retSpr, wbValid;
  logic [RET_W*IDX_W-1:0] retTag, wbTag;
  logic flushValid;
  logic [IDX_W-1:0] flushTag;
  logic [TGT_W-1:0] flushPc;

  always #2 clk = ~clk;

  inorder_retire_unit uut (
    .clk(clk), .rst_n(rst_n), .dispCount(dispCount), .dispEarly(dispEarly),
    .dispSpr(dispSpr), .dispGrant(dispGrant), .dispTag(dispTag),
    .finValid(finValid), .finTag(finTag), .finExc(finExc), .finMisp(finMisp),
    .finTarget(finTarget), .retValid(retValid), .retTag(retTag),
    .commitValid(commitValid), .retSpr(retSpr), .wbValid(wbValid), .wbTag(wbTag),
    .flushValid(flushValid), .flushTag(flushTag), .flushPc(flushPc)
  );

  typedef struct {
    int tag; bit early; bit spr; int kind; logic [31:0] tgt;  // kind 0 ok, 1 exc, 2 misp
  } item_t;

  item_t expQ[$];
  int tests = 0, fails = 0, flushes = 0;
  bit runDone = 1'b0;
  logic [RET_W-1:0] prevWb = '0;
  int prevWbTag [RET_W];

  task automatic chk(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: request n entries; push expected items when granted.
  task automatic dispatch(int n, logic [3:0] early, logic [3:0] spr, bit expGrant);
    @(posedge clk); #1;
    dispCount = DC_W'(n); dispEarly = early; dispSpr = spr;
    #2;
    chk("R3 grant", dispGrant, expGrant);
    if (dispGrant) begin
      for (int i = 0; i < n; i++) begin
        item_t it;
        it.tag = (int'(dispTag) + i) % DEPTH;
        it.early = early[i]; it.spr = spr[i]; it.kind = 0; it.tgt = '0;
        expQ.push_back(it);
      end
    end
    @(posedge clk); #1;
    dispCount = '0;
  endtask

  task automatic markKind(int tag, int kind, logic [31:0] tgt);
    foreach (expQ[j]) if (expQ[j].tag == tag) begin
      expQ[j].kind = kind; expQ[j].tgt = tgt;
    end
  endtask

  // Finish on both ports; a negative tag leaves that port idle.
  task automatic finishPair(int a, bit ea, int b, bit eb, bit mb, logic [31:0] tb);
    @(posedge clk); #1;
    finValid = {b >= 0, a >= 0};
    finTag = {IDX_W'(b < 0 ? 0 : b), IDX_W'(a < 0 ? 0 : a)};
    finExc = {eb, ea}; finMisp = {mb, 1'b0}; finTarget = {tb, 32'h0};
    if (a >= 0 && ea) markKind(a, 1, '0);
    if (b >= 0 && eb) markKind(b, 1, '0);
    if (b >= 0 && mb) markKind(b, 2, tb);
    @(posedge clk); #1;
    finValid = '0; finExc = '0; finMisp = '0;
  endtask

  // Monitor: compares retire, commit, writeback and flush against the queue.
  always @(negedge clk) begin
    if (rst_n) begin
      logic [RET_W-1:0] nextWb;
      int lastKind, lastTag;
      logic [31:0] lastTgt;
      nextWb = '0; lastKind = -1; lastTag = -1; lastTgt = '0;
      for (int k = 0; k < RET_W; k++) begin
        if (wbValid[k] || prevWb[k]) begin
          chk("R10 wbValid", wbValid[k], prevWb[k]);
          if (prevWb[k]) chk("R10 wbTag", wbTag[k*IDX_W +: IDX_W], prevWbTag[k]);
        end
      end
      for (int k = 0; k < RET_W; k++) begin
        if (retValid[k]) begin
          if (expQ.size() == 0) begin
            chk("R4 unexpected retire", retTag[k*IDX_W +: IDX_W], 99);
          end else begin
            item_t it;
            it = expQ.pop_front();
            chk("R4 retTag order", retTag[k*IDX_W +: IDX_W], it.tag);
            chk("R9 commitValid", commitValid[k], it.early);
            chk("R11 retSpr", retSpr[k], it.spr);
            chk("R6 excepting entry retired", it.kind == 1, 0);
            nextWb[k] = !it.early;
            prevWbTag[k] = it.tag;
            lastKind = it.kind; lastTag = it.tag; lastTgt = it.tgt;
          end
        end
      end
      if (flushValid) begin
        flushes++;
        if (lastKind == 2) begin
          chk("R7 flushTag", flushTag, lastTag);
          chk("R7 flushPc", flushPc, lastTgt);
        end else if (expQ.size() > 0) begin
          chk("R6 flushTag", flushTag, expQ[0].tag);
          chk("R6 flush cause", expQ[0].kind, 1);
          chk("R6 flushPc", flushPc, EXC_VEC);
        end
        expQ.delete();
      end else if (lastKind == 2) begin
        chk("R7 missing flush", 0, 1);
      end
      prevWb = nextWb;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!runDone) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 retValid", retValid, 0);
    chk("R1 flushValid", flushValid, 0);
    chk("R1 wbValid", wbValid, 0);
    chk("R1 dispTag", dispTag, 0);
    dispCount = 3'd4; #0.5;
    chk("R1 dispGrant", dispGrant, 1);
    dispCount = '0;

    // S1: out-of-order finish, head last (R12, R5, R4); tags 0..3
    dispatch(4, 4'b0101, 4'b0010, 1);
    finishPair(3, 0, 1, 0, 0, 0);
    @(negedge clk); chk("R5 head unfinished", retValid, 0);
    finishPair(0, 0, 2, 0, 0, 0);
    @(negedge clk); chk("R12 all four retire", retValid, 4'b1111);

    // S2: gap in the middle stops retirement; tags 4..7
    dispatch(4, 4'b0000, 4'b0000, 1);
    finishPair(5, 0, 6, 0, 0, 0);
    @(negedge clk); chk("R5 stop at head", retValid, 0);
    finishPair(4, 0, -1, 0, 0, 0);
    @(negedge clk); chk("R5 run of three", retValid, 4'b0111);
    finishPair(7, 0, -1, 0, 0, 0);
    @(negedge clk); chk("R5 last one", retValid, 4'b0001);

    // S3: fill to capacity; tags 8..15,0..7
    dispatch(4, 4'b1111, 4'b0000, 1);
    chk("R2 group continues", dispTag, 12);
    dispatch(4, 4'b0000, 4'b0000, 1);
    dispatch(4, 4'b1010, 4'b0000, 1);
    dispatch(2, 4'b0000, 4'b0000, 1);
    dispatch(4, 4'b0000, 4'b0000, 0);
    dispatch(2, 4'b0001, 4'b0000, 1);
    dispatch(1, 4'b0000, 4'b0000, 0);
    for (int t = 9; t < 24; t += 2)
      finishPair(t % DEPTH, 0, (t + 1 < 24) ? (t + 1) % DEPTH : -1, 0, 0, 0);
    finishPair(8, 0, -1, 0, 0, 0);
    @(negedge clk);
    chk("R4 four per cycle", retValid, 4'b1111);
    chk("R4 oldest first", retTag[IDX_W-1:0], 8);
    @(negedge clk);
    chk("R4 next group", retTag[IDX_W-1:0], 12);
    repeat (3) @(negedge clk);
    chk("R2 wrap", dispTag, 8);

    // S4: exception on tag 9; tag 8 retires alongside
    dispatch(4, 4'b0000, 4'b0000, 1);
    finishPair(10, 0, 11, 0, 0, 0);
    finishPair(8, 0, 9, 1, 0, 0);
    @(negedge clk);
    chk("R6 older retires", retValid, 4'b0001);
    chk("R6 flush raised", flushValid, 1);
    chk("R6 flushTag", flushTag, 9);
    chk("R6 flushPc", flushPc, EXC_VEC);
    @(negedge clk);
    chk("R8 no retire after flush", retValid, 0);
    chk("R8 no second flush", flushValid, 0);
    chk("R8 restart tag", dispTag, 10);

    // S5: mispredict on tag 11; tags 10..13
    dispatch(4, 4'b0000, 4'b0000, 1);
    finishPair(12, 0, 13, 0, 0, 0);
    finishPair(10, 0, 11, 0, 1, 32'hABC0);
    @(negedge clk);
    chk("R7 retires incl mispredict", retValid, 4'b0011);
    chk("R7 flushTag", flushTag, 11);
    chk("R7 flushPc", flushPc, 32'hABC0);
    @(negedge clk);
    chk("R8 restart tag", dispTag, 12);

    // S6: early commit vs writeback stage and special-register strobe; tags 12..15
    dispatch(4, 4'b0011, 4'b1000, 1);
    finishPair(13, 0, 14, 0, 0, 0);
    finishPair(15, 0, 12, 0, 0, 0);
    @(negedge clk);
    chk("R9 commit lanes", commitValid, 4'b0011);
    chk("R11 spr lanes", retSpr, 4'b1000);
    @(negedge clk);
    chk("R10 wb lanes", wbValid, 4'b1100);
    chk("R10 wb tag lane2", wbTag[2*IDX_W +: IDX_W], 14);

    repeat (3) @(negedge clk);
    chk("R4 queue drained", expQ.size(), 0);
    chk("R8 flush count", flushes, 2);
    runDone = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule